// File: doc/BRIEF.md
# Three-Register Add/Subtract Execute Unit

This block carries out one 16-bit add or subtract instruction per valid strobe. The instruction names a destination and two source entries of a sixteen-entry, 32-bit register file that the block holds internally. One cycle after the strobe, the sum or difference has been written back and the negative, zero, overflow and carry flags have been updated. The block then pulses `done`. An instruction that breaks the register-0 operand rules instead pulses `trap` and changes nothing.

Register 0 is special. As a destination it discards the result, but the flags still change, which gives a compare. As the first operand of a subtract it stands for the constant zero, which gives a negate. As any other source it is illegal. Instruction words whose opcode is neither add nor subtract are left to other units and have no effect here.

A load port fills any register entry, entry 0 included. A read port returns any entry one cycle after its address is presented. Together they give the surrounding pipeline, or a bench, access to the operands and the results.

Top module: `addsub_exec_unit`

## Requirements
- R1: The instruction word carries the opcode in bits 15:12, the destination in 11:8, source 1 in 7:4 and source 2 in 3:0. When `instr_valid` is high with opcode 4'b0011 and both source fields nonzero, the next clock edge writes source1 + source2 (modulo 2^32) into a nonzero destination.
- R2: Opcode 4'b0010 with a nonzero source-2 field writes source1 + ~source2 + 1 (modulo 2^32) into a nonzero destination at the next edge.
- R3: After every accepted instruction, `flag_n` equals bit 31 of the result, and `flag_z` is 1 exactly when all 32 result bits are zero.
- R4: `flag_c` is the carry out of bit 31 of the internal sum, for both operations. After a subtract, 1 therefore means no borrow, that is, source1 >= source2 as unsigned values.
- R5: After an add, `flag_v` is 1 exactly when the two operands have equal sign bits and the result's sign differs from source 1's sign.
- R6: After a subtract, `flag_v` is 1 exactly when the operands' sign bits differ and the result's sign differs from the first operand's sign.
- R7: An add with either source field equal to 0 pulses `trap` at the next edge. It writes no register and leaves all four flags unchanged.
- R8: A subtract with source-2 field equal to 0 pulses `trap` at the next edge. It writes no register and leaves the flags unchanged.
- R9: A subtract with source-1 field 0 uses the constant zero as its first operand, whatever is stored in entry 0, so it yields the negation of source 2.
- R10: A legal add or subtract with destination field 0 updates all four flags but writes no entry. Entry 0 keeps its stored value.
- R11: A valid word whose opcode is neither 4'b0010 nor 4'b0011 produces no `done`, no `trap`, no flag change and no register write.
- R12: Each accepted instruction yields exactly one one-cycle pulse, on `done` or on `trap`, in the cycle after the strobe. Neither pulse occurs without a strobe.
- R13: While `rst` is high, and in the first cycle after it, the flags, `done`, `trap` and `rd_data` are 0.
- R14: `ld_en` writes `ld_data` into entry `ld_addr` at the clock edge, unless an instruction writes back in that same cycle, in which case the load is dropped. `rd_data` presents entry `rd_addr` as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| ld_en | input | 1 | Register load strobe |
| ld_addr | input | 4 | Entry to load |
| ld_data | input | 32 | Value to load |
| rd_addr | input | 4 | Entry to read |
| rd_data | output | 32 | Registered read data |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| trap | output | 1 | Illegal-instruction pulse |
| done | output | 1 | Completion pulse |

## Verification
Several properties are checked on every cycle. Done and trap never pulse together, and neither pulses without a strobe the cycle before. The register-0 source rules always lead to a trap, and a trap or a foreign opcode never moves the flags. The zero flag never appears together with the negative flag. Only the bench's reference model can show that the arithmetic and the V and C values are right across the boundary operands. It also shows that a negate ignores the stored entry 0, that a compare leaves the destination untouched, and that a colliding load is dropped.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int FIELD_W = 4;
  localparam logic [FIELD_W-1:0] OPC_SUB = 4'b0010;
  localparam logic [FIELD_W-1:0] OPC_ADD = 4'b0011;

  typedef struct packed {
    logic [FIELD_W-1:0] opc;
    logic [FIELD_W-1:0] dst;
    logic [FIELD_W-1:0] src1;
    logic [FIELD_W-1:0] src2;
  } instr_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccodes_t;

  typedef struct packed {
    logic accept;
    logic trap;
    logic is_sub;
    logic zero_a;
    logic wr_en;
  } dec_t;
endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
  import addsub_pkg::*;
(
  input  logic   valid,
  input  instr_t word,
  output dec_t   dec
);
  logic is_add, is_sub, src1_r0, src2_r0, bad;

  always_comb begin
    is_add  = (word.opc == OPC_ADD);
    is_sub  = (word.opc == OPC_SUB);
    src1_r0 = (word.src1 == '0);
    src2_r0 = (word.src2 == '0);
    // add may not name r0 as either source; subtract only not as source 2
    bad     = (is_add && (src1_r0 || src2_r0)) || (is_sub && src2_r0);
    dec.trap   = valid && bad;
    dec.accept = valid && (is_add || is_sub) && !bad;
    dec.is_sub = is_sub;
    dec.zero_a = is_sub && src1_r0;
    dec.wr_en  = dec.accept && (word.dst != '0);
  end
endmodule

// File: rtl/addsub_alu.sv
module addsub_alu
  import addsub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] result,
  output ccodes_t           cc
);
  localparam int MSB = DATA_W - 1;
  logic [DATA_W-1:0] b_op;
  logic [DATA_W:0]   total;

  always_comb begin
    b_op   = sub ? ~b : b;
    total  = {1'b0, a} + {1'b0, b_op} + {{DATA_W{1'b0}}, sub};
    result = total[MSB:0];
    cc.n   = total[MSB];
    cc.z   = (total[MSB:0] == '0);
    cc.c   = total[DATA_W];
    cc.v   = (a[MSB] == b_op[MSB]) && (total[MSB] != a[MSB]);
  end
endmodule

// File: rtl/addsub_regfile.sv
module addsub_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     ra1,
  input  logic [AW-1:0]     ra2,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2,
  input  logic [AW-1:0]     ra_dbg,
  output logic [DATA_W-1:0] rd_dbg
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd1 = mem[ra1];
  assign rd2 = mem[ra2];

  always_ff @(posedge clk) begin
    if (rst) rd_dbg <= '0;
    else     rd_dbg <= mem[ra_dbg];
  end
endmodule

// File: rtl/addsub_exec_unit.sv
module addsub_exec_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 16,
  parameter int INSTR_W = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               ld_en,
  input  logic [AW-1:0]      ld_addr,
  input  logic [DATA_W-1:0]  ld_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_v,
  output logic               flag_c,
  output logic               trap,
  output logic               done
);
  instr_t            word;
  dec_t              dec;
  logic [DATA_W-1:0] src1_val, src2_val, op_a, result;
  ccodes_t           alu_cc, cc_q;
  logic              we;
  logic [AW-1:0]     waddr;
  logic [DATA_W-1:0] wdata;

  assign word = instr_t'(instr);

  addsub_decode u_dec (
    .valid (instr_valid),
    .word  (word),
    .dec   (dec)
  );

  // write-back has priority over the load port
  always_comb begin
    we    = dec.wr_en || ld_en;
    waddr = dec.wr_en ? word.dst : ld_addr;
    wdata = dec.wr_en ? result   : ld_data;
  end

  addsub_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (we),
    .waddr  (waddr),
    .wdata  (wdata),
    .ra1    (word.src1),
    .ra2    (word.src2),
    .rd1    (src1_val),
    .rd2    (src2_val),
    .ra_dbg (rd_addr),
    .rd_dbg (rd_data)
  );

  assign op_a = dec.zero_a ? '0 : src1_val;

  addsub_alu #(.DATA_W(DATA_W)) u_alu (
    .a      (op_a),
    .b      (src2_val),
    .sub    (dec.is_sub),
    .result (result),
    .cc     (alu_cc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q <= '0;
      done <= 1'b0;
      trap <= 1'b0;
    end else begin
      done <= dec.accept;
      trap <= dec.trap;
      if (dec.accept) cc_q <= alu_cc;
    end
  end

  assign flag_n = cc_q.n;
  assign flag_z = cc_q.z;
  assign flag_v = cc_q.v;
  assign flag_c = cc_q.c;
endmodule

// File: rtl/addsub_exec_checker.sv
module addsub_exec_checker #(
  parameter int INSTR_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               instr_valid,
  input logic [INSTR_W-1:0] instr,
  input logic               flag_n,
  input logic               flag_z,
  input logic               flag_v,
  input logic               flag_c,
  input logic               trap,
  input logic               done
);
  logic [3:0] fl;
  logic       add_w, sub_w, other_w;
  assign fl      = {flag_n, flag_z, flag_v, flag_c};
  assign add_w   = instr[15:12] == 4'b0011;
  assign sub_w   = instr[15:12] == 4'b0010;
  assign other_w = !add_w && !sub_w;

  p_one_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    !(done && trap));
  p_pulse_needs_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    (done || trap) |-> $past(instr_valid));
  p_add_r0_traps_r7: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && add_w && (instr[7:4] == 4'd0 || instr[3:0] == 4'd0)) |=> trap);
  p_sub_r0_traps_r8: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && sub_w && instr[3:0] == 4'd0) |=> trap);
  p_trap_keeps_flags_r7: assert property (@(posedge clk) disable iff (rst)
    trap |-> $stable(fl));
  p_foreign_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && other_w) |=> (!done && !trap && $stable(fl)));
  p_zero_not_negative_r3: assert property (@(posedge clk) disable iff (rst)
    flag_z |-> !flag_n);
endmodule

bind addsub_exec_unit addsub_exec_checker #(.INSTR_W(INSTR_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr       (instr),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_v      (flag_v),
  .flag_c      (flag_c),
  .trap        (trap),
  .done        (done)
);

// File: tb/test_addsub_exec_unit.sv
module test_addsub_exec_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        flag_n, flag_z, flag_v, flag_c, trap, done;

  addsub_exec_unit i_addsub_exec_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .trap(trap), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [31:0] m_rf [16];
  logic [3:0]  e_fl = '0;
  logic        e_done = 1'b0, e_trap = 1'b0;
  logic [31:0] e_rd = '0;
  bit          rd_chk = 1'b0;
  bit          finished = 1'b0;
  int          n_cmp = 0, n_bad = 0;
  string       tag = "R13";

  task automatic model_edge();
    logic [3:0]  op, d, s1, s2;
    logic [31:0] a, b, res;
    longint      sa, sb, sr;
    logic        wr;
    if (rst) begin
      e_fl = '0; e_done = 0; e_trap = 0; e_rd = '0;
      return;
    end
    e_rd = m_rf[rd_addr];
    op = instr[15:12]; d = instr[11:8]; s1 = instr[7:4]; s2 = instr[3:0];
    e_done = 0; e_trap = 0; wr = 0; res = '0;
    if (instr_valid && (op == 4'd3 || op == 4'd2)) begin
      if ((op == 4'd3 && (s1 == 0 || s2 == 0)) || (op == 4'd2 && s2 == 0)) begin
        e_trap = 1;
      end else begin
        a  = (op == 4'd2 && s1 == 0) ? 32'd0 : m_rf[s1];
        b  = m_rf[s2];
        sa = $signed(a);
        sb = $signed(b);
        if (op == 4'd3) begin
          res = a + b;
          sr  = sa + sb;
          e_fl[0] = ({32'd0, a} + {32'd0, b}) > 64'hFFFF_FFFF;
        end else begin
          res = a - b;
          sr  = sa - sb;
          e_fl[0] = (a >= b);
        end
        e_fl[1] = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        e_fl[2] = (res == 0);
        e_fl[3] = res[31];
        e_done = 1;
        wr = (d != 0);
      end
    end
    if (wr) m_rf[d] = res;
    else if (ld_en) m_rf[ld_addr] = ld_data;
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("done", {31'd0, done}, {31'd0, e_done});
    chk("trap", {31'd0, trap}, {31'd0, e_trap});
    chk("flags", {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, e_fl});
    if (rd_chk) chk("rd_data", rd_data, e_rd);
  endtask

  task automatic load(input logic [3:0] a, input logic [31:0] v);
    ld_en = 1; ld_addr = a; ld_data = v;
    cycle();
    ld_en = 0;
  endtask

  task automatic issue(input string t, input logic [3:0] op, d, s1, s2);
    tag = t;
    instr = {op, d, s1, s2}; instr_valid = 1; rd_addr = d;
    cycle();
    instr_valid = 0;
    cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tag = "R13";
    repeat (3) cycle();
    rst = 0;
    cycle();
    tag = "R14";
    for (int i = 0; i < 16; i++) load(i[3:0], 32'h1000_0000 + i);
    load(4'd0, 32'hDEAD_BEEF);
    load(4'd1, 32'd5);
    load(4'd2, 32'd7);
    load(4'd4, 32'h7FFF_FFFF);
    load(4'd5, 32'd1);
    load(4'd6, 32'hFFFF_FFFF);
    load(4'd7, 32'h8000_0000);
    load(4'd8, 32'h1234_5678);
    rd_chk = 1;
    for (int i = 0; i < 16; i++) begin rd_addr = i[3:0]; cycle(); end

    issue("R1 R3", 4'd3, 4'd9,  4'd1, 4'd2);
    issue("R5 R3", 4'd3, 4'd10, 4'd4, 4'd5);
    issue("R4 R3", 4'd3, 4'd11, 4'd6, 4'd5);
    issue("R5 R4", 4'd3, 4'd12, 4'd7, 4'd7);
    issue("R2 R4", 4'd2, 4'd13, 4'd1, 4'd2);
    issue("R2 R4", 4'd2, 4'd13, 4'd2, 4'd1);
    issue("R6", 4'd2, 4'd14, 4'd7, 4'd5);
    issue("R6", 4'd2, 4'd14, 4'd4, 4'd6);
    issue("R3 R4", 4'd2, 4'd15, 4'd8, 4'd8);
    issue("R9", 4'd2, 4'd9, 4'd0, 4'd8);
    issue("R9", 4'd2, 4'd9, 4'd0, 4'd7);
    issue("R10", 4'd2, 4'd0, 4'd1, 4'd2);
    issue("R10", 4'd3, 4'd0, 4'd6, 4'd5);
    issue("R7", 4'd3, 4'd9, 4'd0, 4'd2);
    issue("R7", 4'd3, 4'd9, 4'd1, 4'd0);
    issue("R8", 4'd2, 4'd9, 4'd1, 4'd0);
    issue("R11", 4'd5, 4'd9, 4'd1, 4'd2);
    issue("R11", 4'd0, 4'd10, 4'd4, 4'd5);

    tag = "R12";
    instr_valid = 1;
    instr = {4'd3, 4'd3, 4'd1, 4'd1}; rd_addr = 4'd3; cycle();
    instr = {4'd3, 4'd3, 4'd3, 4'd3}; cycle();
    instr = {4'd2, 4'd3, 4'd3, 4'd0}; cycle();
    instr = {4'd2, 4'd3, 4'd0, 4'd3}; cycle();
    instr_valid = 0; cycle();

    tag = "R14";
    instr = {4'd3, 4'd9, 4'd1, 4'd2}; instr_valid = 1;
    ld_en = 1; ld_addr = 4'd9; ld_data = 32'hCAFE_0001; rd_addr = 4'd9;
    cycle();
    instr_valid = 0; ld_en = 0; cycle();
    instr = {4'd3, 4'd10, 4'd1, 4'd2}; instr_valid = 1;
    ld_en = 1; ld_addr = 4'd11; ld_data = 32'hCAFE_0002; rd_addr = 4'd11;
    cycle();
    instr_valid = 0; ld_en = 0; cycle();
    rd_addr = 4'd10; cycle(); cycle();

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule